// File: doc/BRIEF.md
# Tamper Detection Response Controller

This block collects the digital tamper indications of a secure module and turns the first violation into a fixed erase sequence that software cannot stop. The indications are a pair of complementary protective-mesh sense lines, three out-of-range flags (temperature, supply glitch, light inside the enclosure), and a heartbeat pulse from the monitoring circuitry. A heartbeat that stops counting down to zero is treated the same as any other tamper.

Every violation sets a sticky bit in a cause register, and the alert line follows that register. Once any cause bit is set, the sequencer cuts power to the battery-backed key RAM with a one-cycle strobe. It then overwrites each word of the non-volatile key area with words taken from an entropy stream. The entropy input is a valid/ready stream. `ent_ready` is high only while the overwrite runs. A word is consumed, and written to the key area, in exactly those cycles where `ent_valid` and `ent_ready` are both high. When `ent_valid` is low, the sequencer waits and the write address holds. When the last address has been written, `zero_done` rises and stays high until a power-on reset.

Top module: `tamper_resp_ctrl`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `cause` is 0, and `alert`, `keyram_cut`, `nv_we`, `ent_ready` and `zero_done` are all low.
- R2: The mesh is healthy when `mesh_a` differs from `mesh_b`. Both lines low means open and sets `cause[0]`. Both lines high means short and sets `cause[1]`. The bad state must be present on 2 consecutive cycles, and the bit then appears in the following cycle. A bad state lasting one cycle sets nothing.
- R3: `temp_bad` sets `cause[2]`, `volt_bad` sets `cause[3]` and `light_bad` sets `cause[4]`, each independently, one cycle after the flag is sampled high. Every cause bit stays set until reset.
- R4: A heartbeat down-counter is loaded with HB_TIMEOUT (default 1024) at reset and on every `hb_pulse`. If it reaches zero, `cause[5]` is set. Pulses spaced closer than HB_TIMEOUT cycles never set it.
- R5: `alert` is high in every cycle in which any `cause` bit is set.
- R6: `keyram_cut` is high for exactly one cycle, the cycle after the first cause bit appears, and only once per reset.
- R7: In the cycle after the `keyram_cut` strobe, the overwrite begins with `ent_ready` high. Each accepted entropy word is written with `nv_we` high and `nv_wdata` equal to `ent_data`. The writes go to addresses 0 up to 2^ADDR_W-1 in ascending order, and each address is written exactly once.
- R8: During the overwrite, a cycle with `ent_valid` low produces no write, and `nv_addr` keeps its value.
- R9: After the last address is written, `zero_done` is high from the next cycle. It stays high until reset, `ent_ready` stays low, and further tamper events produce no more writes or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| mesh_a | input | 1 | Mesh sense line, high when healthy |
| mesh_b | input | 1 | Complementary mesh sense line, low when healthy |
| temp_bad | input | 1 | Temperature out of range |
| volt_bad | input | 1 | Supply glitch detected |
| light_bad | input | 1 | Light detected inside enclosure |
| hb_pulse | input | 1 | Monitoring heartbeat pulse |
| ent_data | input | DATA_W | Entropy word |
| ent_valid | input | 1 | Entropy word valid |
| ent_ready | output | 1 | Entropy word accepted (overwrite running) |
| cause | output | 6 | Sticky tamper cause bits |
| alert | output | 1 | Tamper alert |
| keyram_cut | output | 1 | One-cycle key RAM power-cut strobe |
| nv_we | output | 1 | Key area write enable |
| nv_addr | output | ADDR_W | Key area write address |
| nv_wdata | output | DATA_W | Key area write data |
| zero_done | output | 1 | Overwrite complete |

## Verification
The hardest situations to reach from the ports are the heartbeat expiry and the overwrite running under a gappy entropy stream. For the expiry, the stimulus pulses the heartbeat for several timeout periods and then stops. It samples `cause[5]` just before and just after the expected expiry cycle. For the overwrite, the stimulus withholds `ent_valid` on every third cycle and queues each word it offers. A monitor matches each write against that queue, so any extra, missing, reordered or stalled-through write shows up as a mismatch. Single-cycle mesh glitches are applied first so that the two-cycle filter is tested before any real tamper occurs.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int CAUSE_W   = 6;
  localparam int C_OPEN    = 0;
  localparam int C_SHORT   = 1;
  localparam int C_TEMP    = 2;
  localparam int C_VOLT    = 3;
  localparam int C_LIGHT   = 4;
  localparam int C_HB      = 5;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_CUT   = 2'd1,
    ST_WIPE  = 2'd2,
    ST_DONE  = 2'd3
  } zstate_t;
endpackage

// File: rtl/mesh_filter.sv
module mesh_filter #(
  parameter int HOLD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_a,
  input  logic line_b,
  output logic open_det,
  output logic short_det
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LIM = CW'(HOLD - 1);

  logic [1:0] bad_now;
  logic [1:0] det;

  assign bad_now[0] = ~line_a & ~line_b;
  assign bad_now[1] =  line_a &  line_b;

  for (genvar g = 0; g < 2; g++) begin : g_cond
    logic [CW-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0;
      end else if (!bad_now[g]) begin
        run <= '0;
      end else if (run != LIM) begin
        run <= run + 1'b1;
      end
    end
    assign det[g] = bad_now[g] && (run == LIM);
  end

  assign open_det  = det[0];
  assign short_det = det[1];
endmodule

// File: rtl/hb_watchdog.sv
module hb_watchdog #(
  parameter int HB_TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_pulse,
  output logic expired
);
  localparam int CNT_W = $clog2(HB_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HB_TIMEOUT);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= RELOAD;
    end else if (hb_pulse) begin
      cnt <= RELOAD;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/zeroize_fsm.sv
module zeroize_fsm
  import tamper_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tamper,
  input  logic              ent_valid,
  output logic              ent_ready,
  output logic              keyram_cut,
  output logic              nv_we,
  output logic [ADDR_W-1:0] nv_addr,
  output logic              zero_done
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  zstate_t state, state_nx;
  logic [ADDR_W-1:0] addr;
  logic take;

  assign take = (state == ST_WIPE) && ent_valid;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_ARMED: if (tamper) state_nx = ST_CUT;
      ST_CUT:   state_nx = ST_WIPE;
      ST_WIPE:  if (take && addr == LAST) state_nx = ST_DONE;
      ST_DONE:  state_nx = ST_DONE;
      default:  state_nx = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_ARMED;
      addr  <= '0;
    end else begin
      state <= state_nx;
      if (take) addr <= addr + 1'b1;
    end
  end

  assign ent_ready  = (state == ST_WIPE);
  assign keyram_cut = (state == ST_CUT);
  assign nv_we      = take;
  assign nv_addr    = addr;
  assign zero_done  = (state == ST_DONE);
endmodule

// File: rtl/tamper_resp_ctrl.sv
module tamper_resp_ctrl
  import tamper_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int HB_TIMEOUT = 1024,
  parameter int MESH_HOLD  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mesh_a,
  input  logic               mesh_b,
  input  logic               temp_bad,
  input  logic               volt_bad,
  input  logic               light_bad,
  input  logic               hb_pulse,
  input  logic [DATA_W-1:0]  ent_data,
  input  logic               ent_valid,
  output logic               ent_ready,
  output logic [CAUSE_W-1:0] cause,
  output logic               alert,
  output logic               keyram_cut,
  output logic               nv_we,
  output logic [ADDR_W-1:0]  nv_addr,
  output logic [DATA_W-1:0]  nv_wdata,
  output logic               zero_done
);
  logic open_det, short_det, hb_expired;
  logic [CAUSE_W-1:0] hit;
  logic [CAUSE_W-1:0] cause_q;

  mesh_filter #(.HOLD(MESH_HOLD)) u_mesh (
    .clk(clk), .rst_n(rst_n), .line_a(mesh_a), .line_b(mesh_b),
    .open_det(open_det), .short_det(short_det)
  );

  hb_watchdog #(.HB_TIMEOUT(HB_TIMEOUT)) u_hb (
    .clk(clk), .rst_n(rst_n), .hb_pulse(hb_pulse), .expired(hb_expired)
  );

  always_comb begin
    hit          = '0;
    hit[C_OPEN]  = open_det;
    hit[C_SHORT] = short_det;
    hit[C_TEMP]  = temp_bad;
    hit[C_VOLT]  = volt_bad;
    hit[C_LIGHT] = light_bad;
    hit[C_HB]    = hb_expired;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_q | hit;
  end

  zeroize_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tamper(|cause_q), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .keyram_cut(keyram_cut), .nv_we(nv_we),
    .nv_addr(nv_addr), .zero_done(zero_done)
  );

  assign cause    = cause_q;
  assign alert    = |cause_q;
  assign nv_wdata = ent_data;
endmodule

// File: rtl/tamper_resp_chk.sv
module tamper_resp_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        cause,
  input logic              alert,
  input logic              keyram_cut,
  input logic              ent_valid,
  input logic              ent_ready,
  input logic              nv_we,
  input logic [ADDR_W-1:0] nv_addr,
  input logic              zero_done
);
  // R3
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((cause & $past(cause)) == $past(cause)));

  // R6
  cut_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyram_cut |=> !keyram_cut);

  // R6
  cut_after_alert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyram_cut |-> alert);

  // R7
  cut_then_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    keyram_cut |=> ent_ready);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> (zero_done || nv_addr == $past(nv_addr) + 1'b1));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_ready && !ent_valid) |=> $stable(nv_addr));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_done |=> (zero_done && !ent_ready && !nv_we && !keyram_cut));
endmodule

bind tamper_resp_ctrl tamper_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cause(cause), .alert(alert),
  .keyram_cut(keyram_cut), .ent_valid(ent_valid), .ent_ready(ent_ready),
  .nv_we(nv_we), .nv_addr(nv_addr), .zero_done(zero_done)
);

// File: tb/tb_tamper_resp_ctrl.sv
module tb_tamper_resp_ctrl;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mesh_a, mesh_b, temp_bad, volt_bad, light_bad, hb_pulse;
  logic [DW-1:0] ent_data;
  logic ent_valid, ent_ready, alert, keyram_cut, nv_we, zero_done;
  logic [5:0] cause;
  logic [AW-1:0] nv_addr;
  logic [DW-1:0] nv_wdata;

  tamper_resp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mesh_a(mesh_a), .mesh_b(mesh_b),
    .temp_bad(temp_bad), .volt_bad(volt_bad), .light_bad(light_bad),
    .hb_pulse(hb_pulse), .ent_data(ent_data), .ent_valid(ent_valid),
    .ent_ready(ent_ready), .cause(cause), .alert(alert),
    .keyram_cut(keyram_cut), .nv_we(nv_we), .nv_addr(nv_addr),
    .nv_wdata(nv_wdata), .zero_done(zero_done)
  );

  int checks = 0;
  int fails = 0;
  logic [AW+DW-1:0] expq[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor: samples 3 ns after each falling edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n && nv_we) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8 unexpected write", {28'd0, nv_addr, nv_wdata}, 64'd0);
      end else begin
        logic [AW+DW-1:0] item;
        item = expq.pop_front();
        chk({nv_addr, nv_wdata} == item, "R7 write", {28'd0, nv_addr, nv_wdata},
            {28'd0, item});
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic do_reset();
    rst_n = 1'b0; mesh_a = 1'b1; mesh_b = 1'b0; temp_bad = 1'b0;
    volt_bad = 1'b0; light_bad = 1'b0; hb_pulse = 1'b0;
    ent_valid = 1'b0; ent_data = '0;
    repeat (3) @(negedge clk);
    chk(cause == 0 && !alert && !keyram_cut && !nv_we && !ent_ready && !zero_done,
        "R1 in reset", {58'd0, cause}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cause == 0 && !alert && !keyram_cut && !ent_ready && !zero_done,
        "R1 after reset", {58'd0, cause}, 64'd0);
  endtask

  initial begin
    // ---------- test A: glitches, temperature tamper, full wipe
    do_reset();
    mesh_a = 1'b0; mesh_b = 1'b0;
    @(negedge clk);
    mesh_a = 1'b1;
    @(negedge clk);
    mesh_a = 1'b1; mesh_b = 1'b1;
    @(negedge clk);
    mesh_b = 1'b0;
    repeat (3) @(negedge clk);
    chk(cause == 0 && !alert, "R2 glitch ignored", {58'd0, cause}, 64'd0);

    temp_bad = 1'b1;
    @(negedge clk);
    chk(cause == 6'h04, "R3 temp cause", {58'd0, cause}, 64'h04);
    chk(alert && !keyram_cut, "R5 alert", {62'd0, alert, keyram_cut}, 64'h2);
    temp_bad = 1'b0;
    @(negedge clk);
    chk(keyram_cut && !ent_ready, "R6 cut strobe", {62'd0, keyram_cut, ent_ready}, 64'h2);
    @(negedge clk);
    chk(!keyram_cut && ent_ready, "R7 wipe start", {62'd0, keyram_cut, ent_ready}, 64'h1);

    begin
      int k = 0;
      int cyc = 0;
      while (k < WORDS) begin
        bit v;
        v = (cyc % 3) != 2;
        ent_valid = v;
        ent_data = 32'h5A00_0000 ^ (32'h0101_0101 * (k + 1)) ^ cyc;
        if (v) begin
          expq.push_back({AW'(k), ent_data});
          k++;
        end else begin
          #1;
          chk(!nv_we && nv_addr == AW'(k), "R8 stall", {59'd0, nv_we, nv_addr},
              {60'd0, AW'(k)});
        end
        cyc++;
        @(negedge clk);
      end
    end
    ent_valid = 1'b0;
    chk(zero_done && !ent_ready, "R9 done", {62'd0, zero_done, ent_ready}, 64'h2);
    chk(cause == 6'h04, "R3 sticky", {58'd0, cause}, 64'h04);
    #4;
    chk(expq.size() == 0, "R7 all words written", expq.size(), 64'd0);
    mesh_a = 1'b0; mesh_b = 1'b0; ent_valid = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(zero_done && !ent_ready && !keyram_cut, "R9 stays done",
          {61'd0, zero_done, ent_ready, keyram_cut}, 64'h4);
    end
    chk(cause == 6'h05, "R2 open after done", {58'd0, cause}, 64'h05);
    ent_valid = 1'b0;

    // ---------- test B: mesh open held
    do_reset();
    mesh_a = 1'b0; mesh_b = 1'b0;
    @(negedge clk);
    chk(cause == 0, "R2 open first cycle", {58'd0, cause}, 64'd0);
    @(negedge clk);
    chk(cause == 6'h01 && alert, "R2 open", {58'd0, cause}, 64'h01);
    @(negedge clk);
    chk(keyram_cut, "R6 cut after open", {63'd0, keyram_cut}, 64'h1);

    // ---------- test C: mesh short held
    do_reset();
    mesh_a = 1'b1; mesh_b = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(cause == 6'h02, "R2 short", {58'd0, cause}, 64'h02);

    // ---------- test D: supply then light, sticky
    do_reset();
    volt_bad = 1'b1;
    @(negedge clk);
    volt_bad = 1'b0;
    chk(cause == 6'h08, "R3 volt", {58'd0, cause}, 64'h08);
    light_bad = 1'b1;
    @(negedge clk);
    light_bad = 1'b0;
    chk(cause == 6'h18, "R3 light", {58'd0, cause}, 64'h18);
    repeat (4) @(negedge clk);
    chk(cause == 6'h18 && alert, "R3 sticky flags", {58'd0, cause}, 64'h18);

    // ---------- test E: heartbeat
    do_reset();
    repeat (5) begin
      repeat (700) @(negedge clk);
      hb_pulse = 1'b1;
      @(negedge clk);
      hb_pulse = 1'b0;
    end
    chk(cause == 0, "R4 heartbeat alive", {58'd0, cause}, 64'd0);
    repeat (1010) @(negedge clk);
    chk(cause == 0, "R4 before expiry", {58'd0, cause}, 64'd0);
    repeat (20) @(negedge clk);
    chk(cause == 6'h20 && alert, "R4 expiry", {58'd0, cause}, 64'h20);

    summary();
  end
endmodule